// File: doc/BRIEF.md
# Endian-Switchable Byte-Cell Word Memory

This block is a synchronous on-chip memory whose storage is organised as byte-wide cells, each with its own byte address, while every access moves a full 32-bit word. A load or store names its location as a base value plus a signed 16-bit displacement. The block forms the sum, finds the group of four adjacent cells that holds the word, and places the bytes on the data path in the requested order.

A run-time select picks between two byte orders. With little-endian ordering the lowest-addressed cell carries the least significant byte. With big-endian ordering it carries the most significant byte. The select only changes how bytes are gathered and scattered on each access. The cells themselves are never reordered, so a word stored with one ordering and read with the other comes back byte-reversed.

Accesses must be word aligned. An address with nonzero low bits raises an error flag. A store to such an address does not write, and a load from it returns zero. Read data is registered and appears on the clock after the read strobe.

Top module: `endian_word_mem`

## Requirements
- R1: While reset is asserted and on the first edge after it, rdata_o is 0 and misalign_o is 0.
- R2: The byte address is base_i plus offset_i sign-extended from bit 15, taken modulo DEPTH_BYTES (256 by default), so address bits at and above bit 8 are ignored.
- R3: With big_endian_i = 0, the cell at the lowest address of the word maps to data bits 7:0, and each next-higher address maps to the next-higher byte of the data (bits 15:8, 23:16, 31:24).
- R4: With big_endian_i = 1, the cell at the lowest address maps to bits 31:24, and each next-higher address maps to the next-lower byte. For example, cells 4..7 holding AA, BB, CC, DD read as 0xAABBCCDD.
- R5: A store (wr_i = 1) at an aligned address writes all four bytes of wdata_i. A load (rd_i = 1) presents the word on rdata_o one clock later. rdata_o keeps its value in every cycle that follows a cycle with rd_i = 0.
- R6: An address whose bits 1:0 are not 00 is misaligned. In the clock after a strobed access (rd_i or wr_i) to such an address, misalign_o is 1. A misaligned store leaves every cell unchanged. A misaligned load returns 0.
- R7: When rd_i and wr_i are both set in the same cycle, the load returns the cell contents as they were before that store.
- R8: Changing big_endian_i does not alter stored bytes. A word stored with one ordering and loaded with the other returns with its four bytes reversed.
- R9: misalign_o is 0 in the clock after a cycle with neither rd_i nor wr_i set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base address value |
| offset_i | input | 16 | Signed displacement added to the base |
| wdata_i | input | 32 | Word to store |
| rd_i | input | 1 | Load strobe |
| wr_i | input | 1 | Store strobe |
| big_endian_i | input | 1 | Byte order select: 1 big-endian, 0 little-endian |
| rdata_o | output | 32 | Registered load result |
| misalign_o | output | 1 | Misaligned-access flag for the previous cycle's access |

## Verification
The assertions assume that the strobes, base, offset and order select hold known values on every clock edge once reset has been released. Only under that assumption does the alignment decode give a definite answer, and only then can a write enable or a hold of the read register be judged. The stimulus changes all inputs on the falling clock edge and always drives defined values. It keeps about four accesses in five aligned by adjusting the base to match the random displacement, so stores land and reads return real data. The rest are left misaligned on purpose so that write suppression and the zero read are exercised.

// File: rtl/ewm_pkg.sv
package ewm_pkg;

   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   // lane that carries data byte 'pos' of a word for the given order
   function automatic int unsigned lane_of(input byte_order_e order,
                                           input int unsigned pos,
                                           input int unsigned lanes);
      return (order == ORDER_BIG) ? (lanes - 1 - pos) : pos;
   endfunction

endpackage

// File: rtl/ewm_agen.sv
module ewm_agen #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int LANES  = 4,
   parameter int WORDS  = 64,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  offset_i,
   output logic [IDX_W-1:0]  word_idx_o,
   output logic              misaligned_o
);

   localparam int EXT_W = ADDR_W - OFF_W;
   localparam logic [ADDR_W-1:0] LANE_DIV  = ADDR_W'(LANES);
   localparam logic [ADDR_W-1:0] WORD_DIV  = ADDR_W'(WORDS);

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] eff_addr;
   logic [ADDR_W-1:0] word_num;

   assign off_ext  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
   assign eff_addr = base_i + off_ext;
   assign word_num = eff_addr / LANE_DIV;

   assign misaligned_o = (eff_addr % LANE_DIV) != '0;
   assign word_idx_o   = IDX_W'(word_num % WORD_DIV);

endmodule

// File: rtl/ewm_lane_map.sv
module ewm_lane_map
   import ewm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  byte_order_e               order_i,
   input  logic [BYTE_W*LANES-1:0]   src_i,
   output logic [BYTE_W*LANES-1:0]   dst_o
);

   // The mapping is its own inverse, so one block serves both directions.
   for (genvar g_pos = 0; g_pos < LANES; g_pos++) begin : g_pos_sel
      localparam int MIRROR = LANES - 1 - g_pos;
      always_comb begin
         if (order_i == ORDER_BIG)
            dst_o[g_pos*BYTE_W +: BYTE_W] = src_i[MIRROR*BYTE_W +: BYTE_W];
         else
            dst_o[g_pos*BYTE_W +: BYTE_W] = src_i[g_pos*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/ewm_byte_bank.sv
module ewm_byte_bank #(
   parameter int BYTE_W = 8,
   parameter int WORDS  = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              re_i,
   input  logic              zero_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o
);

   logic [BYTE_W-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we_i)
         cells[idx_i] <= wdata_i;
   end

   // read port sees the contents before any same-edge write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else if (re_i)
         rdata_o <= zero_i ? '0 : cells[idx_i];
   end

endmodule

// File: rtl/endian_word_mem.sv
module endian_word_mem
   import ewm_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 16,
   parameter int BYTE_W      = 8,
   parameter int LANES       = 4,
   parameter int DEPTH_BYTES = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         base_i,
   input  logic [OFF_W-1:0]          offset_i,
   input  logic [BYTE_W*LANES-1:0]   wdata_i,
   input  logic                      rd_i,
   input  logic                      wr_i,
   input  logic                      big_endian_i,
   output logic [BYTE_W*LANES-1:0]   rdata_o,
   output logic                      misalign_o
);

   localparam int WORD_W = BYTE_W * LANES;
   localparam int WORDS  = DEPTH_BYTES / LANES;
   localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (DEPTH_BYTES < LANES || (DEPTH_BYTES & (DEPTH_BYTES - 1)) != 0) begin : g_bad_depth
      $error("DEPTH_BYTES must be a power of two no smaller than LANES");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed OFF_W");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be positive");
   end

   logic [IDX_W-1:0]  word_idx;
   logic              addr_bad;
   logic              bank_we;
   byte_order_e       order_now;
   byte_order_e       order_q;
   logic [WORD_W-1:0] wr_lanes;
   logic [WORD_W-1:0] rd_lanes;

   assign order_now = big_endian_i ? ORDER_BIG : ORDER_LITTLE;
   assign bank_we   = wr_i & ~addr_bad;

   ewm_agen #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .LANES  (LANES),
      .WORDS  (WORDS),
      .IDX_W  (IDX_W)
   ) u_agen (
      .base_i       (base_i),
      .offset_i     (offset_i),
      .word_idx_o   (word_idx),
      .misaligned_o (addr_bad)
   );

   ewm_lane_map #(
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_wmap (
      .order_i (order_now),
      .src_i   (wdata_i),
      .dst_o   (wr_lanes)
   );

   for (genvar g_lane = 0; g_lane < LANES; g_lane++) begin : g_bank
      ewm_byte_bank #(
         .BYTE_W (BYTE_W),
         .WORDS  (WORDS),
         .IDX_W  (IDX_W)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (bank_we),
         .re_i    (rd_i),
         .zero_i  (addr_bad),
         .idx_i   (word_idx),
         .wdata_i (wr_lanes[g_lane*BYTE_W +: BYTE_W]),
         .rdata_o (rd_lanes[g_lane*BYTE_W +: BYTE_W])
      );
   end

   // order captured with the read so the output matches its request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         order_q <= ORDER_LITTLE;
      else if (rd_i)
         order_q <= order_now;
   end

   ewm_lane_map #(
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_rmap (
      .order_i (order_q),
      .src_i   (rd_lanes),
      .dst_o   (rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         misalign_o <= 1'b0;
      else
         misalign_o <= (rd_i | wr_i) & addr_bad;
   end

endmodule

// File: rtl/ewm_checker.sv
module ewm_checker #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_i,
   input logic              wr_i,
   input logic              addr_bad,
   input logic              bank_we,
   input logic [WORD_W-1:0] rdata_o,
   input logic              misalign_o
);

   // R9
   idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && !wr_i) |=> !misalign_o);

   // R6
   bad_addr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_i || wr_i) && addr_bad) |=> misalign_o);

   // R6
   bad_store_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_bad |-> !bank_we);

   // R6
   bad_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_bad) |=> (rdata_o == '0));

   // R5
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));

endmodule

bind endian_word_mem ewm_checker #(.WORD_W(BYTE_W*LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_i       (rd_i),
   .wr_i       (wr_i),
   .addr_bad   (addr_bad),
   .bank_we    (bank_we),
   .rdata_o    (rdata_o),
   .misalign_o (misalign_o)
);

// File: tb/endian_word_mem_tb.sv
`timescale 1ns/1ps
module endian_word_mem_tb;

   localparam int DEPTH = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] offset_i = '0;
   logic [31:0] wdata_i = '0;
   logic        rd_i = 1'b0;
   logic        wr_i = 1'b0;
   logic        big_endian_i = 1'b0;
   logic [31:0] rdata_o;
   logic        misalign_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0]  model [DEPTH];
   logic [31:0] exp_rd = '0;

   always #2.5 clk = ~clk;

   endian_word_mem u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_i       (base_i),
      .offset_i     (offset_i),
      .wdata_i      (wdata_i),
      .rd_i         (rd_i),
      .wr_i         (wr_i),
      .big_endian_i (big_endian_i),
      .rdata_o      (rdata_o),
      .misalign_o   (misalign_o)
   );

   function automatic logic [31:0] eff(input logic [31:0] b, input logic [15:0] o);
      return b + {{16{o[15]}}, o};
   endfunction

   function automatic logic [31:0] gather(input logic [31:0] a, input bit big);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
         if (big) w[8*(3-i) +: 8] = model[(a + i) % DEPTH];
         else     w[8*i +: 8]     = model[(a + i) % DEPTH];
      end
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic access(input bit rd, input bit wr, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d,
                         input bit big, input string req);
      logic [31:0] a;
      bit          mis;
      a   = eff(b, o);
      mis = (a[1:0] != 2'b00);
      if (rd) exp_rd = mis ? 32'h0 : gather(a, big);
      @(negedge clk);
      base_i = b; offset_i = o; wdata_i = d;
      rd_i = rd; wr_i = wr; big_endian_i = big;
      @(posedge clk);
      #1;
      check(rdata_o == exp_rd, req, "rdata", rdata_o, exp_rd);
      check(misalign_o == ((rd | wr) & mis), req, "misalign",
            {31'b0, misalign_o}, {31'b0, (rd | wr) & mis});
      if (wr && !mis) begin
         for (int i = 0; i < 4; i++) begin
            if (big) model[(a + i) % DEPTH] = d[8*(3-i) +: 8];
            else     model[(a + i) % DEPTH] = d[8*i +: 8];
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
      // clear the memory so its contents are defined
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs during reset
      check(rdata_o == 32'h0, "R1", "rdata in reset", rdata_o, 32'h0);
      check(misalign_o == 1'b0, "R1", "misalign in reset", {31'b0, misalign_o}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(rdata_o == 32'h0, "R1", "rdata after reset", rdata_o, 32'h0);
      for (int w = 0; w < DEPTH / 4; w++)
         access(1'b0, 1'b1, 32'(w * 4), 16'h0, 32'h0, 1'b0, "R5");

      // R3: little-endian store of AA..DD at 4..7
      access(1'b0, 1'b1, 32'd4, 16'd0, 32'hDDCCBBAA, 1'b0, "R3");
      // R2 R4 R8: big-endian load at 8 + (-4)
      access(1'b1, 1'b0, 32'd8, 16'hFFFC, 32'h0, 1'b1, "R4");
      @(negedge clk); rd_i = 1'b0; wr_i = 1'b0;
      #0;
      check(rdata_o == 32'hAABBCCDD, "R4", "big load literal", rdata_o, 32'hAABBCCDD);
      access(1'b1, 1'b0, 32'd0, 16'd4, 32'h0, 1'b0, "R3");
      @(negedge clk); rd_i = 1'b0;
      check(rdata_o == 32'hDDCCBBAA, "R8", "little reload literal", rdata_o, 32'hDDCCBBAA);

      // R6: misaligned store suppressed, misaligned load zero
      access(1'b0, 1'b1, 32'd5, 16'd0, 32'h12345678, 1'b0, "R6");
      access(1'b1, 1'b0, 32'd4, 16'd0, 32'h0, 1'b1, "R6");
      access(1'b1, 1'b0, 32'd6, 16'd1, 32'h0, 1'b0, "R6");
      // R9 and R5 hold: idle cycle
      access(1'b0, 1'b0, 32'd7, 16'd0, 32'h0, 1'b1, "R9");
      // R7: read and write together
      access(1'b1, 1'b1, 32'd4, 16'd0, 32'h01020304, 1'b0, "R7");
      access(1'b1, 1'b0, 32'd4, 16'd0, 32'h0, 1'b0, "R7");
      // R2: wrap above depth
      access(1'b0, 1'b1, 32'h00000100, 16'd8, 32'hCAFEF00D, 1'b1, "R2");
      access(1'b1, 1'b0, 32'd8, 16'd0, 32'h0, 1'b1, "R2");
      access(1'b1, 1'b0, 32'd12, 16'hFFFC, 32'h0, 1'b0, "R8");

      // random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] b;
         logic [15:0] o;
         logic [31:0] a;
         bit          rd, wr;
         b  = $urandom;
         o  = 16'($urandom);
         a  = eff(b, o);
         if (($urandom % 5) != 0) b = b - {30'b0, a[1:0]};
         rd = $urandom_range(0, 1);
         wr = $urandom_range(0, 1);
         access(rd, wr, b, o, $urandom, 1'($urandom_range(0, 1)), "R5");
      end

      access(1'b0, 1'b0, 32'd0, 16'd0, 32'h0, 1'b0, "R9");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule